// File: doc/BRIEF.md
# Filtered Inbound PCIe Traffic Monitor

This block watches the request stream that one PCIe root complex sends toward memory and keeps a small bank of free-running 64-bit event counters. Every request presents the index of the root port it entered on, the requester ID, a destination class, a read/write flag and a byte count. A shared filter decides whether a request is of interest. Each counter then adds a value chosen by its own event selector: request counts, byte totals, elapsed fabric cycles, or the number of reads in flight, which is accumulated once per cycle.

The source side of the filter works in one of two modes, and only one applies at a time. In the first, a root port bitmask admits requests by port. In the second, a single exact requester-ID match admits requests. This requester ID is packed as bus<<8 | device<<3 | function. The destination side is a per-class mask. When a mask is left at zero, nothing is filtered on that side. Software programs the filter, the event selectors, a global run bit and per-counter clears through a simple word-addressed register port. It reads the counters back through the same port. Latency is derived from two counters: the accumulated in-flight reads divided by the read request count.

Top module: `pcie_inbound_monitor`

## Requirements
- R1: After reset all counters read 0, and the control, source, destination and event-select registers read 0.
- R2: With requester-ID matching off, bit p of the port mask (source register at 0x04, bits 7:0) admits requests from root port p. An all-zero mask admits every port.
- R3: Setting bit 8 of the source register enables requester-ID matching against bits 31:16 of the same register. Only requests whose ID is equal are admitted, and the port mask has no effect. The one match value serves every counter.
- R4: Destination register 0x08 bits 4:0 admit classes 0 (local CPU memory), 1 (local GPU memory), 2 (local PCIe peer), 3 (local CXL memory) and 4 (remote memory). An all-zero mask admits all classes. A request is counted only when both its source and its destination are admitted.
- R5: Event select register 0x10+4*i (bits 2:0) picks what counter i adds per admitted request. Code 0 adds 1 per read, code 1 adds 1 per write, code 2 adds the byte count of each read, and code 3 adds the byte count of each write. Codes 6 and 7 add nothing.
- R6: An in-flight read tracker rises by one for every read request, whatever the filter says, and falls by one on each completion. When both happen in the same cycle it holds. A completion at zero is ignored. Code 4 adds the tracker value held before each clock edge.
- R7: Code 5 adds one per clock edge.
- R8: Bit 0 of control register 0x00 is the run bit. While it reads 0 no counter changes except through a clear. Writes to it take effect from the following cycle.
- R9: Writing register 0x0C with bit i set zeroes counter i. The clear wins over any increment in the same cycle.
- R10: Counter i reads at 0x40+8*i (low word) and 0x44+8*i (high word). The source register reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_is_write | input | 1 | 1 for a write request, 0 for a read |
| req_port | input | 3 | Root port index of the request |
| req_rid | input | 16 | Requester bus/device/function ID |
| req_dest | input | 3 | Destination class code |
| req_bytes | input | 12 | Bytes carried by the request |
| cpl_valid | input | 1 | One read completes this cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |

## Verification
The accumulated in-flight event is the hardest behaviour to drive from the ports. It only shows a non-trivial sum when the tracker sits at several different non-zero levels while the run bit is open. It also has to survive a read and a completion landing together, and completions arriving at zero. The stimulus builds a burst of reads with no completions, then overlaps reads with completions, then sends more completions than there are reads in flight. The expected total is summed cycle by cycle in the bench. Filter coverage comes from sweeping every port, destination class and direction under a grid of port and destination masks, followed by the requester-ID mode with a port mask that would otherwise exclude the matching traffic.

// File: rtl/pim_pkg.sv
package pim_pkg;
  typedef enum logic [2:0] {
    EV_RD_REQ   = 3'd0,
    EV_WR_REQ   = 3'd1,
    EV_RD_BYTES = 3'd2,
    EV_WR_BYTES = 3'd3,
    EV_RD_OUTS  = 3'd4,
    EV_CYCLES   = 3'd5
  } event_e;

  localparam int DST_CLASSES = 5;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 32;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_SRC  = 8'h04;
  localparam logic [ADDR_W-1:0] ADR_DST  = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_CLR  = 8'h0C;
  localparam logic [ADDR_W-1:0] ADR_SEL  = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_CTR  = 8'h40;
endpackage

// File: rtl/pim_filter.sv
module pim_filter
  import pim_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic [NUM_PORTS-1:0]   port_mask,
  input  logic                   bdf_en,
  input  logic [15:0]            bdf,
  input  logic [DST_CLASSES-1:0] dst_mask,
  input  logic [PORT_W-1:0]      req_port,
  input  logic [15:0]            req_rid,
  input  logic [2:0]             req_dest,
  output logic                   hit
);
  logic [NUM_PORTS-1:0]   port_sel;
  logic [DST_CLASSES-1:0] dst_sel;
  logic                   src_ok;
  logic                   dst_ok;

  always_comb begin
    port_sel = '0;
    port_sel[req_port] = 1'b1;
    dst_sel = '0;
    if (32'(req_dest) < DST_CLASSES) dst_sel[req_dest] = 1'b1;
    // exact ID mode overrides the port mask entirely
    if (bdf_en) src_ok = (req_rid == bdf);
    else        src_ok = (port_mask == '0) || (|(port_mask & port_sel));
    dst_ok = (dst_mask == '0) || (|(dst_mask & dst_sel));
    hit    = src_ok && dst_ok;
  end
endmodule

// File: rtl/pim_outstanding.sv
module pim_outstanding #(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [OUT_W-1:0] count
);
  localparam logic [OUT_W-1:0] MAX_CNT = '1;

  logic [OUT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec && cnt_q != MAX_CNT) cnt_d = cnt_q + 1'b1;
    if (dec && !inc && cnt_q != '0)      cnt_d = cnt_q - 1'b1;
    cnt_en = inc ^ dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/pim_counter.sv
module pim_counter
  import pim_pkg::*;
#(
  parameter int CTR_W  = 64,
  parameter int BYTE_W = 12,
  parameter int OUT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [2:0]        sel,
  input  logic              rd_hit,
  input  logic              wr_hit,
  input  logic [BYTE_W-1:0] bytes,
  input  logic [OUT_W-1:0]  outs,
  output logic [CTR_W-1:0]  val
);
  logic [CTR_W-1:0] val_q, val_d, step;
  logic             val_en;

  always_comb begin
    case (sel)
      EV_RD_REQ:   step = CTR_W'(rd_hit);
      EV_WR_REQ:   step = CTR_W'(wr_hit);
      EV_RD_BYTES: step = rd_hit ? CTR_W'(bytes) : '0;
      EV_WR_BYTES: step = wr_hit ? CTR_W'(bytes) : '0;
      EV_RD_OUTS:  step = CTR_W'(outs);
      EV_CYCLES:   step = CTR_W'(1);
      default:     step = '0;
    endcase
    val_en = clr || run;
    val_d  = clr ? '0 : val_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  assign val = val_q;
endmodule

// File: rtl/pcie_inbound_monitor.sv
module pcie_inbound_monitor
  import pim_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int NUM_CTRS  = 4,
  parameter int CTR_W     = 64,
  parameter int BYTE_W    = 12,
  parameter int OUT_W     = 8,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_write,
  input  logic [PORT_W-1:0] req_port,
  input  logic [15:0]       req_rid,
  input  logic [2:0]        req_dest,
  input  logic [BYTE_W-1:0] req_bytes,
  input  logic              cpl_valid,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic                          run_q, run_d;
  logic [NUM_PORTS-1:0]          pmask_q, pmask_d;
  logic                          bdfen_q, bdfen_d;
  logic [15:0]                   bdf_q, bdf_d;
  logic [DST_CLASSES-1:0]        dmask_q, dmask_d;
  logic [NUM_CTRS-1:0][2:0]      sel_q, sel_d;
  logic [NUM_CTRS-1:0]           sel_we, clr_vec;
  logic                          wr_ctrl, wr_src, wr_dst;
  logic                          unused_wdata;

  assign wr_ctrl      = reg_we && (reg_addr == ADR_CTRL);
  assign wr_src       = reg_we && (reg_addr == ADR_SRC);
  assign wr_dst       = reg_we && (reg_addr == ADR_DST);
  assign unused_wdata = ^reg_wdata[15:9];

  always_comb begin
    run_d   = reg_wdata[0];
    pmask_d = reg_wdata[NUM_PORTS-1:0];
    bdfen_d = reg_wdata[8];
    bdf_d   = reg_wdata[31:16];
    dmask_d = reg_wdata[DST_CLASSES-1:0];
    for (int i = 0; i < NUM_CTRS; i++) begin
      sel_we[i]  = reg_we && (reg_addr == ADDR_W'(ADR_SEL + 4*i));
      sel_d[i]   = reg_wdata[2:0];
      clr_vec[i] = reg_we && (reg_addr == ADR_CLR) && reg_wdata[i];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_q   <= 1'b0;
      pmask_q <= '0;
      bdfen_q <= 1'b0;
      bdf_q   <= '0;
      dmask_q <= '0;
      sel_q   <= '0;
    end else begin
      if (wr_ctrl) run_q <= run_d;
      if (wr_src) begin
        pmask_q <= pmask_d;
        bdfen_q <= bdfen_d;
        bdf_q   <= bdf_d;
      end
      if (wr_dst) dmask_q <= dmask_d;
      for (int i = 0; i < NUM_CTRS; i++)
        if (sel_we[i]) sel_q[i] <= sel_d[i];
    end
  end

  logic             hit, rd_hit, wr_hit;
  logic [OUT_W-1:0] outs_cnt;

  pim_filter #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) i_filter (
    .port_mask(pmask_q), .bdf_en(bdfen_q), .bdf(bdf_q), .dst_mask(dmask_q),
    .req_port(req_port), .req_rid(req_rid), .req_dest(req_dest), .hit(hit)
  );

  assign rd_hit = req_valid && !req_is_write && hit;
  assign wr_hit = req_valid &&  req_is_write && hit;

  pim_outstanding #(.OUT_W(OUT_W)) i_outs (
    .clk(clk), .rst_n(rst_int_n),
    .inc(req_valid && !req_is_write), .dec(cpl_valid), .count(outs_cnt)
  );

  logic [NUM_CTRS-1:0][CTR_W-1:0] ctr_val;

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_ctr
    pim_counter #(.CTR_W(CTR_W), .BYTE_W(BYTE_W), .OUT_W(OUT_W)) i_ctr (
      .clk(clk), .rst_n(rst_int_n), .run(run_q), .clr(clr_vec[g]),
      .sel(sel_q[g]), .rd_hit(rd_hit), .wr_hit(wr_hit),
      .bytes(req_bytes), .outs(outs_cnt), .val(ctr_val[g])
    );
  end

  always_comb begin
    logic [63:0] wide;
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL: reg_rdata[0] = run_q;
      ADR_SRC: begin
        reg_rdata[NUM_PORTS-1:0] = pmask_q;
        reg_rdata[8]             = bdfen_q;
        reg_rdata[31:16]         = bdf_q;
      end
      ADR_DST: reg_rdata[DST_CLASSES-1:0] = dmask_q;
      default: reg_rdata = '0;
    endcase
    for (int i = 0; i < NUM_CTRS; i++) begin
      wide = 64'(ctr_val[i]);
      if (reg_addr == ADDR_W'(ADR_SEL + 4*i))     reg_rdata = DATA_W'(sel_q[i]);
      if (reg_addr == ADDR_W'(ADR_CTR + 8*i))     reg_rdata = wide[31:0];
      if (reg_addr == ADDR_W'(ADR_CTR + 8*i + 4)) reg_rdata = wide[63:32];
    end
  end
endmodule

// File: rtl/pim_checker.sv
module pim_checker
  import pim_pkg::*;
#(
  parameter int NUM_CTRS = 4,
  parameter int CTR_W    = 64,
  parameter int OUT_W    = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_is_write,
  input logic                          cpl_valid,
  input logic [OUT_W-1:0]              outs,
  input logic                          run,
  input logic [NUM_CTRS-1:0][CTR_W-1:0] ctr_val,
  input logic                          reg_we,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [NUM_CTRS-1:0]           clr_bits
);
  logic rd_req;
  logic clr_wr;
  assign rd_req = req_valid && !req_is_write;
  assign clr_wr = reg_we && (reg_addr == ADR_CLR);

  assert_trk_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !cpl_valid && outs != '1) |=> (outs == $past(outs) + 1'b1));

  assert_trk_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !rd_req && outs != '0) |=> (outs == $past(outs) - 1'b1));

  assert_trk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && rd_req) |=> $stable(outs));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr_wr) |=> $stable(ctr_val));

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_clr
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_bits[g]) |=> (ctr_val[g] == '0));
  end
endmodule

bind pcie_inbound_monitor pim_checker #(
  .NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W), .OUT_W(OUT_W)
) i_chk (
  .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid),
  .req_is_write(req_is_write), .cpl_valid(cpl_valid), .outs(outs_cnt),
  .run(run_q), .ctr_val(ctr_val), .reg_we(reg_we), .reg_addr(reg_addr),
  .clr_bits(reg_wdata[NUM_CTRS-1:0])
);

// File: tb/test_pcie_inbound_monitor.sv
`timescale 1ns/1ps
module test_pcie_inbound_monitor;
  import pim_pkg::*;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_is_write, cpl_valid, reg_we;
  logic [2:0]  req_port, req_dest;
  logic [15:0] req_rid;
  logic [11:0] req_bytes;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #2.5 clk = ~clk;

  pcie_inbound_monitor i_pcie_inbound_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_write(req_is_write),
    .req_port(req_port), .req_rid(req_rid), .req_dest(req_dest),
    .req_bytes(req_bytes), .cpl_valid(cpl_valid), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit          m_run, m_bdfen;
  logic [7:0]  m_pmask;
  logic [15:0] m_bdf;
  logic [4:0]  m_dmask;
  logic [2:0]  m_sel [NC];
  logic [63:0] m_ctr [NC];
  int          m_trk;

  function automatic bit admits(logic [2:0] p, logic [15:0] rid, logic [2:0] d);
    bit s, t;
    if (m_bdfen) s = (rid == m_bdf);
    else         s = (m_pmask == 0) || m_pmask[p];
    t = (m_dmask == 0) || ((d < 5) && m_dmask[d]);
    return s && t;
  endfunction

  task automatic tick();
    bit hit;
    logic [63:0] step;
    @(posedge clk);
    hit = req_valid && admits(req_port, req_rid, req_dest);
    for (int c = 0; c < NC; c++) begin
      case (m_sel[c])
        3'd0: step = (hit && !req_is_write) ? 64'd1 : 64'd0;
        3'd1: step = (hit &&  req_is_write) ? 64'd1 : 64'd0;
        3'd2: step = (hit && !req_is_write) ? 64'(req_bytes) : 64'd0;
        3'd3: step = (hit &&  req_is_write) ? 64'(req_bytes) : 64'd0;
        3'd4: step = 64'(m_trk);
        3'd5: step = 64'd1;
        default: step = 64'd0;
      endcase
      if (reg_we && reg_addr == ADR_CLR && reg_wdata[c]) m_ctr[c] = 64'd0;
      else if (m_run) m_ctr[c] = m_ctr[c] + step;
    end
    if (req_valid && !req_is_write && !cpl_valid && m_trk < 255) m_trk++;
    if (cpl_valid && !(req_valid && !req_is_write) && m_trk > 0) m_trk--;
    if (reg_we) begin
      if (reg_addr == ADR_CTRL) m_run = reg_wdata[0];
      if (reg_addr == ADR_SRC) begin
        m_pmask = reg_wdata[7:0]; m_bdfen = reg_wdata[8]; m_bdf = reg_wdata[31:16];
      end
      if (reg_addr == ADR_DST) m_dmask = reg_wdata[4:0];
      for (int c = 0; c < NC; c++)
        if (reg_addr == 8'(ADR_SEL + 4*c)) m_sel[c] = reg_wdata[2:0];
    end
    @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic send(logic [2:0] p, logic [15:0] rid, logic [2:0] d, bit w,
                      logic [11:0] b, bit cpl);
    req_valid = 1'b1; req_port = p; req_rid = rid; req_dest = d;
    req_is_write = w; req_bytes = b; cpl_valid = cpl;
    tick();
    req_valid = 1'b0; cpl_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic check_ctrs(string tag);
    logic [31:0] lo, hi;
    for (int c = 0; c < NC; c++) begin
      rd(8'(ADR_CTR + 8*c), lo);
      rd(8'(ADR_CTR + 8*c + 4), hi);
      check({hi, lo} == m_ctr[c], tag, {hi, lo}, m_ctr[c]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  pms [4];
    logic [4:0]  dms [4];
    logic [15:0] rids [5];
    pms = '{8'h00, 8'h01, 8'hA5, 8'hFF};
    dms = '{5'h00, 5'h01, 5'h12, 5'h1F};
    rids = '{16'h2781, 16'h2780, 16'h2681, 16'hA781, 16'h2781};
    m_run = 0; m_bdfen = 0; m_pmask = 0; m_bdf = 0; m_dmask = 0; m_trk = 0;
    for (int c = 0; c < NC; c++) begin m_sel[c] = 0; m_ctr[c] = 0; end
    rst_n = 1'b0; req_valid = 0; req_is_write = 0; cpl_valid = 0; reg_we = 0;
    req_port = 0; req_rid = 0; req_dest = 0; req_bytes = 0;
    reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check_ctrs("R1 counter after reset");
    rd(ADR_CTRL, d); check(d == 0, "R1 control after reset", d, 0);
    rd(ADR_SRC, d);  check(d == 0, "R1 source after reset", d, 0);
    rd(ADR_DST, d);  check(d == 0, "R1 dest after reset", d, 0);
    rd(ADR_SEL, d);  check(d == 0, "R1 select after reset", d, 0);

    // R2 R4 R5: sweep every port, class and direction under mask grid
    wr(8'h10, 0); wr(8'h14, 1); wr(8'h18, 2); wr(8'h1C, 3);
    wr(ADR_CTRL, 1);
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        wr(ADR_SRC, {24'h0, pms[a]});
        wr(ADR_DST, {27'h0, dms[b]});
        wr(ADR_CLR, 32'hF);
        for (int p = 0; p < 8; p++)
          for (int dc = 0; dc < 5; dc++)
            for (int w = 0; w < 2; w++)
              send(3'(p), 16'(p*7 + dc), 3'(dc), w[0], 12'(p*16 + dc*4 + w + 1), !w[0]);
        check_ctrs("R2/R4/R5 mask sweep");
      end
    end

    // R3: exact ID mode, port mask 0x01 must not matter
    wr(ADR_SRC, {16'h2781, 7'h0, 1'b1, 8'h01});
    rd(ADR_SRC, d);
    check(d == 32'h2781_0101, "R10 source readback", d, 32'h2781_0101);
    wr(ADR_DST, 0);
    wr(ADR_CLR, 32'hF);
    for (int r = 0; r < 5; r++)
      for (int p = 0; p < 8; p++)
        for (int w = 0; w < 2; w++)
          send(3'(p), rids[r], 3'(p % 5), w[0], 12'(r*40 + p + 3), !w[0]);
    check_ctrs("R3 ID match ignores port mask");
    wr(ADR_DST, 32'h04);
    wr(ADR_CLR, 32'hF);
    for (int r = 0; r < 5; r++)
      for (int dc = 0; dc < 5; dc++)
        send(3'(r), rids[r], 3'(dc), r[0], 12'(dc*9 + 1), !r[0]);
    check_ctrs("R3/R4 ID match with dest mask");

    // R6 R7: in-flight accumulation and cycles; codes 6 adds nothing
    wr(ADR_SRC, 0); wr(ADR_DST, 0);
    wr(ADR_CTRL, 0);
    wr(8'h10, 4); wr(8'h14, 5); wr(8'h18, 0); wr(8'h1C, 6);
    wr(ADR_CLR, 32'hF);
    wr(ADR_CTRL, 1);
    for (int k = 0; k < 5; k++) send(3'(k), 16'h0, 3'd0, 1'b0, 12'd32, 1'b0);
    idle(3);
    for (int k = 0; k < 2; k++) send(3'(k), 16'h0, 3'd1, 1'b0, 12'd32, 1'b1);
    send(3'd2, 16'h0, 3'd1, 1'b1, 12'd64, 1'b1);
    idle(4);
    for (int k = 0; k < 7; k++) begin cpl_valid = 1'b1; tick(); end
    cpl_valid = 1'b0;
    send(3'd0, 16'h0, 3'd0, 1'b0, 12'd16, 1'b0);
    idle(2);
    wr(ADR_CTRL, 0);
    check_ctrs("R6/R7 in-flight and cycles");

    // R8: frozen while run bit is clear
    wr(8'h10, 0); wr(8'h14, 1);
    for (int p = 0; p < 8; p++) send(3'(p), 16'h1, 3'd2, p[0], 12'd100, 1'b0);
    idle(3);
    check_ctrs("R8 frozen counters");

    // R9: clear wins over a same-cycle increment
    wr(ADR_CTRL, 1);
    for (int p = 0; p < 4; p++) send(3'(p), 16'h1, 3'd2, 1'b0, 12'd8, 1'b0);
    reg_we = 1'b1; reg_addr = ADR_CLR; reg_wdata = 32'h5;
    req_valid = 1'b1; req_is_write = 1'b0; req_port = 0; req_dest = 0;
    tick();
    reg_we = 1'b0; req_valid = 1'b0;
    check_ctrs("R9 clear priority");
    for (int p = 0; p < 3; p++) send(3'(p), 16'h1, 3'd2, 1'b1, 12'd8, 1'b1);
    check_ctrs("R9/R5 after clear");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule